// File: doc/BRIEF.md
# Pipeline Exception Controller

This block is the exception control logic of a five-stage in-order pipeline. Each cycle it receives an illegal-opcode flag for the instruction sitting in decode and an arithmetic-overflow flag for the instruction sitting in execute. Each flag comes with that stage's valid bit and program counter. When either exception is raised on a valid instruction, the controller picks the one that belongs to the oldest instruction. The execute-stage instruction is always older than the decode-stage one.

When an exception is taken, the controller squashes the faulting instruction and everything younger. It leaves older instructions to retire. It steers the fetch unit to a single fixed handler entry point. On the same clock edge that loads the handler address into the PC, it stores the faulting instruction's address plus one instruction width in a 64-bit link register. It also stores the cause in a 32-bit syndrome register.

The execute-stage register-write enable passes through the block. When the execute stage is flushed, that write is blocked, so an overflowing instruction never updates its destination register.

Top module: `exc_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `elr` and `esr` read zero. With no exception flag raised, all flushes and `pc_sel_handler` stay low.
- R2: Whenever an exception is taken, `flush_if`, `flush_id` and `pc_sel_handler` are high in that same cycle, and `handler_pc` equals 0x0000_0000_1C09_0000.
- R3: A valid execute-stage overflow asserts `flush_ex` in the same cycle. A decode-stage illegal opcode taken alone leaves `flush_ex` low, so the older execute instruction completes.
- R4: On the clock edge that ends a cycle with `pc_sel_handler` high, `elr` is loaded with the faulting instruction's PC plus 4, computed modulo 2^64 (a PC of 0xFFFF_FFFF_FFFF_FFFC yields 0).
- R5: On the same edge, `esr` is loaded with bit 0 set to the cause (0 = illegal opcode, 1 = overflow) and bits 31:1 cleared.
- R6: When both flags are raised on valid instructions in the same cycle, the overflow is taken. `elr` then gets the execute PC plus 4 and `esr[0]` becomes 1.
- R7: `ex_reg_wr_ok` equals `ex_reg_wr` except in a cycle where `flush_ex` is high, where it is 0.
- R8: In a cycle with no exception taken, `elr` and `esr` keep their values across the following clock edge.
- R9: An exception flag whose stage valid bit is low is ignored. It causes no flush, no redirect and no change of `elr` or `esr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_undef | input | 1 | Decode found an illegal opcode |
| id_pc | input | 64 | PC of the decode-stage instruction |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_ovf | input | 1 | Execute produced an arithmetic overflow |
| ex_pc | input | 64 | PC of the execute-stage instruction |
| ex_reg_wr | input | 1 | Register-write enable of the execute-stage instruction |
| flush_if | output | 1 | Zero the fetched instruction in the IF/ID register |
| flush_id | output | 1 | Zero the control fields entering ID/EX |
| flush_ex | output | 1 | Zero the control fields entering EX/MEM |
| pc_sel_handler | output | 1 | PC mux select: load `handler_pc` next |
| handler_pc | output | 64 | Fixed handler entry address |
| ex_reg_wr_ok | output | 1 | Register-write enable after the execute flush |
| elr | output | 64 | Exception link register |
| esr | output | 32 | Exception syndrome register |

## Verification
The assertions assume the flags are only meaningful together with their stage valid bits. They also assume the PC inputs are stable and known whenever a valid bit is high. The bench drives every input at the falling edge from a single task and always gives both PCs defined values. As a result, no flag or PC changes while the rising edge samples it.

The bench never raises a flag in two consecutive cycles for an instruction that would already have been flushed. Every stimulus cycle is treated as a fresh pipeline state, which matches the way the real pipeline turns squashed slots into bubbles.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam int SYND_W = 32;

  typedef enum logic {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } exc_cause_e;

  // Syndrome word: cause in bit 0, the rest reserved as zero.
  function automatic logic [SYND_W-1:0] syndrome_of(input exc_cause_e c);
    logic [SYND_W-1:0] w;
    w    = '0;
    w[0] = c;
    return w;
  endfunction
endpackage

// File: rtl/exc_ctrl_arb.sv
module exc_ctrl_arb
  import exc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              id_valid,
  input  logic              id_undef,
  input  logic [ADDR_W-1:0] id_pc,
  input  logic              ex_valid,
  input  logic              ex_ovf,
  input  logic [ADDR_W-1:0] ex_pc,
  output logic              take,
  output logic              take_ex,
  output exc_cause_e        cause,
  output logic [ADDR_W-1:0] fault_pc
);
  logic id_hit;
  logic ex_hit;

  assign id_hit = id_valid && id_undef;
  assign ex_hit = ex_valid && ex_ovf;

  // The execute-stage instruction is older, so it wins.
  always_comb begin
    take_ex  = ex_hit;
    take     = ex_hit || id_hit;
    cause    = ex_hit ? CAUSE_OVF : CAUSE_UNDEF;
    fault_pc = ex_hit ? ex_pc : id_pc;
  end
endmodule

// File: rtl/exc_ctrl_flush.sv
module exc_ctrl_flush (
  input  logic take,
  input  logic take_ex,
  input  logic ex_reg_wr,
  output logic flush_if,
  output logic flush_id,
  output logic flush_ex,
  output logic redirect,
  output logic reg_wr_ok
);
  // Every taken exception squashes IF and ID (faulting or younger).
  // EX is squashed only when it holds the faulting instruction.
  always_comb begin
    flush_if  = take;
    flush_id  = take;
    flush_ex  = take_ex;
    redirect  = take;
    reg_wr_ok = ex_reg_wr && !take_ex;
  end
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  exc_cause_e        cause,
  input  logic [ADDR_W-1:0] fault_pc,
  output logic [ADDR_W-1:0] elr,
  output logic [SYND_W-1:0] esr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elr <= '0;
      esr <= '0;
    end else if (take) begin
      elr <= fault_pc + STEP;
      esr <= syndrome_of(cause);
    end
  end

  // R4
  elr_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> elr == $past(fault_pc) + STEP);

  // R5
  esr_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> esr[SYND_W-1:1] == '0);
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter int              ADDR_W     = 64,
  parameter int              INSN_BYTES = 4,
  parameter logic [63:0]     ENTRY_ADDR = 64'h0000_0000_1C09_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic              id_undef,
  input  logic [ADDR_W-1:0] id_pc,
  input  logic              ex_valid,
  input  logic              ex_ovf,
  input  logic [ADDR_W-1:0] ex_pc,
  input  logic              ex_reg_wr,
  output logic              flush_if,
  output logic              flush_id,
  output logic              flush_ex,
  output logic              pc_sel_handler,
  output logic [ADDR_W-1:0] handler_pc,
  output logic              ex_reg_wr_ok,
  output logic [ADDR_W-1:0] elr,
  output logic [SYND_W-1:0] esr
);
  logic              exc_take;
  logic              exc_take_ex;
  exc_cause_e        exc_cause;
  logic [ADDR_W-1:0] exc_pc;

  exc_ctrl_arb #(.ADDR_W(ADDR_W)) u_arb (
    .id_valid (id_valid),
    .id_undef (id_undef),
    .id_pc    (id_pc),
    .ex_valid (ex_valid),
    .ex_ovf   (ex_ovf),
    .ex_pc    (ex_pc),
    .take     (exc_take),
    .take_ex  (exc_take_ex),
    .cause    (exc_cause),
    .fault_pc (exc_pc)
  );

  exc_ctrl_flush u_flush (
    .take      (exc_take),
    .take_ex   (exc_take_ex),
    .ex_reg_wr (ex_reg_wr),
    .flush_if  (flush_if),
    .flush_id  (flush_id),
    .flush_ex  (flush_ex),
    .redirect  (pc_sel_handler),
    .reg_wr_ok (ex_reg_wr_ok)
  );

  exc_ctrl_regs #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (exc_take),
    .cause    (exc_cause),
    .fault_pc (exc_pc),
    .elr      (elr),
    .esr      (esr)
  );

  assign handler_pc = ADDR_W'(ENTRY_ADDR);

  // R2
  flush_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel_handler |-> flush_if && flush_id);

  // R3
  ovf_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ovf) |-> flush_ex && pc_sel_handler);

  // R6
  oldest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ovf && id_valid && id_undef) |=> esr[0] == 1'b1);

  // R7
  no_fault_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ex |-> !ex_reg_wr_ok);

  // R8
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_sel_handler |=> $stable(elr) && $stable(esr));

  // R9
  bubble_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid && !ex_valid) |-> !pc_sel_handler && !flush_ex);
endmodule

// File: tb/exc_ctrl_bench.sv
module exc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid = 1'b0, id_undef = 1'b0, ex_valid = 1'b0, ex_ovf = 1'b0, ex_reg_wr = 1'b0;
  logic [63:0] id_pc = '0, ex_pc = '0;
  logic        flush_if, flush_id, flush_ex, pc_sel_handler, ex_reg_wr_ok;
  logic [63:0] handler_pc, elr;
  logic [31:0] esr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct { logic [63:0] elr; logic [31:0] esr; string tag; } exp_t;
  exp_t sb_q[$];
  logic [63:0] m_elr = '0;
  logic [31:0] m_esr = '0;

  always #2 clk = ~clk;

  exc_ctrl u_exc_ctrl (
    .clk(clk), .rst_n(rst_n),
    .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc), .ex_reg_wr(ex_reg_wr),
    .flush_if(flush_if), .flush_id(flush_id), .flush_ex(flush_ex),
    .pc_sel_handler(pc_sel_handler), .handler_pc(handler_pc),
    .ex_reg_wr_ok(ex_reg_wr_ok), .elr(elr), .esr(esr)
  );

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one pipeline state, checks same-cycle outputs,
  // and pushes the register state expected after the next edge.
  task automatic apply(string tag, logic iv, logic iu, logic [63:0] ip,
                       logic ev, logic eo, logic [63:0] ep, logic wr);
    logic hit_ex, hit_id, any;
    @(negedge clk);
    id_valid = iv; id_undef = iu; id_pc = ip;
    ex_valid = ev; ex_ovf = eo; ex_pc = ep; ex_reg_wr = wr;
    hit_ex = ev & eo;
    hit_id = iv & iu;
    any    = hit_ex | hit_id;
    #1;
    check64({tag, " R2 redirect"}, {63'b0, pc_sel_handler}, {63'b0, any});
    check64({tag, " R2 flush_if/id"}, {62'b0, flush_if, flush_id}, {62'b0, any, any});
    check64({tag, " R3 flush_ex"}, {63'b0, flush_ex}, {63'b0, hit_ex});
    check64({tag, " R7 write enable"}, {63'b0, ex_reg_wr_ok}, {63'b0, wr & ~hit_ex});
    if (any) check64({tag, " R2 handler_pc"}, handler_pc, 64'h0000_0000_1C09_0000);
    if (hit_ex) begin
      m_elr = ep + 64'd4; m_esr = 32'd1;
    end else if (hit_id) begin
      m_elr = ip + 64'd4; m_esr = 32'd0;
    end
    sb_q.push_back('{m_elr, m_esr, tag});
  endtask

  // Monitor: compares the registers after each edge with the queued item.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check64({e.tag, " R4/R8 elr"}, elr, e.elr);
        check64({e.tag, " R5/R8 esr"}, {32'b0, esr}, {32'b0, e.esr});
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check64("R1 elr reset", elr, 64'd0);
    check64("R1 esr reset", {32'b0, esr}, 64'd0);
    check64("R1 redirect reset", {63'b0, pc_sel_handler}, 64'd0);
    rst_n = 1'b1;
    apply("R1 idle", 1, 0, 64'h40, 1, 0, 64'h3C, 1);
    apply("R2 undef", 1, 1, 64'h100, 1, 0, 64'hFC, 1);
    apply("R8 hold", 1, 0, 64'h200, 1, 0, 64'h1FC, 0);
    apply("R3 ovf", 1, 0, 64'h2004, 1, 1, 64'h2000, 1);
    apply("R8 hold2", 0, 0, 64'h0, 0, 0, 64'h0, 1);
    apply("R6 both", 1, 1, 64'h5004, 1, 1, 64'h5000, 1);
    apply("R9 id bubble", 0, 1, 64'h7000, 1, 0, 64'h6FFC, 1);
    apply("R9 ex bubble", 1, 0, 64'h8004, 0, 1, 64'h8000, 1);
    apply("R5 undef cause", 1, 1, 64'h9000, 0, 0, 64'h0, 0);
    apply("R4 wrap", 0, 0, 64'h0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFC, 1);
    apply("R7 id only write", 1, 1, 64'hA000, 1, 0, 64'h9FFC, 1);
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply("R6 mix", lfsr[0], lfsr[1], {48'h0, lfsr} << 2, lfsr[2], lfsr[3] & lfsr[4],
            {44'h0, lfsr, 4'h0}, lfsr[5]);
    end
    apply("R8 tail", 0, 0, 64'h0, 0, 0, 64'h0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule